// File: doc/BRIEF.md
# Boot Overlay and Banked Work-RAM Address Decoder

This block sits between a CPU's 16-bit byte-addressed bus and the memories and peripherals behind it. For every access it works out which region the address falls in and raises one select line: boot ROM, cartridge ROM, cartridge RAM, video unit, work RAM or peripheral I/O. When the target is work RAM, it also gives the translated internal work-RAM address. The read data it returns comes from the selected source, or from one of its own small registers.

The block holds three pieces of state:
- a boot-active flag, which lets a boot ROM cover the low addresses after reset until the flag is cleared;
- a work-RAM bank register, which chooses what appears in the upper 4 KB work-RAM window;
- the interrupt-enable byte.

A colour-mode input does two things: it opens a second boot window, and it allows the bank register to choose among eight 4 KB banks (32 KB). In mono mode the work RAM is 8 KB and the upper window is always bank 1. Cartridge bank logic and peripheral register contents are outside this block. It reaches them through select lines and read-data inputs.

Top module: `boot_mem_decoder`

## Requirements
- R1: While boot is active, reads of 0x0000–0x00FE select boot ROM (sel_boot, rdata = boot_rdata). 0x00FF, 0x0100–0x01FF, all writes to 0x0000–0x7FFF, and any read once boot is inactive select cartridge ROM (sel_cart_rom).
- R2: A read of exactly 0x00FE while boot is active still returns boot ROM data, and boot_active is low from the next clock edge on.
- R3: In colour mode (color_mode=1) with boot active, reads of 0x0200–0x08FF also select boot ROM. In mono mode those addresses select cartridge ROM.
- R4: A write of any value to 0xFF50 clears boot_active. A read of 0xFF50 returns 0x01 while boot is active and 0x00 otherwise. Once cleared, the flag stays low until reset. Reset sets it to 1.
- R5: 0xC000–0xCFFF selects work RAM at wram_addr = addr[11:0]. 0xD000–0xDFFF selects work RAM at wram_addr = bank×0x1000 + addr[11:0], where bank is the bank register in colour mode and is 1 in mono mode.
- R6: A write to 0xFF70 stores bits 2:0 of the data, and a stored value of 0 becomes 1. Reset value is 1. A read of 0xFF70 returns the bank zero-extended.
- R7: 0xE000–0xFDFF selects work RAM at wram_addr = addr[12:0], whatever the bank register holds.
- R8: 0x8000–0x9FFF, 0xFE00–0xFEFF and 0xFF80–0xFFFE select the video unit. 0xA000–0xBFFF selects cartridge RAM.
- R9: 0xFFFF is the interrupt-enable register. A write loads it, a read returns it, ie_mask shows it, and its reset value is 0x00.
- R10: Within 0xFF00–0xFF7F, sel_io is raised for offsets 0x00–0x02, 0x04–0x07, 0x0F, 0x10–0x4F, 0x51–0x55, 0x60–0x6F and 0x71–0x7F. Reads of the other offsets, except 0x50 and 0x70, return 0x00, and writes to them change nothing.
- R11: At most one select line is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| color_mode | input | 1 | 1 = colour mode (extra boot window, 8 banks) |
| bus_addr | input | 16 | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| boot_rdata | input | DATA_W | Boot ROM read data |
| cart_rdata | input | DATA_W | Cartridge ROM/RAM read data |
| video_rdata | input | DATA_W | Video unit read data |
| wram_rdata | input | DATA_W | Work-RAM read data |
| io_rdata | input | DATA_W | Peripheral register read data |
| sel_boot | output | 1 | Boot ROM selected |
| sel_cart_rom | output | 1 | Cartridge ROM space selected |
| sel_cart_ram | output | 1 | Cartridge RAM space selected |
| sel_video | output | 1 | Video unit selected |
| sel_wram | output | 1 | Work RAM selected |
| sel_io | output | 1 | External peripheral register selected |
| wram_addr | output | BANK_W+12 | Translated work-RAM byte address |
| boot_active | output | 1 | Boot overlay flag |
| ie_mask | output | DATA_W | Interrupt-enable register |
| rdata | output | DATA_W | Read data returned to the bus |

## Verification
Two functions can meet in one cycle: a read of 0x00FE is served from boot ROM in the same cycle that it schedules the clear of the overlay. The bench samples rdata and sel_boot during that read, and then checks that boot_active has dropped and that 0x0000 now reads cartridge data. A second case is a bank write followed at once by an access to the banked window. The bench checks that the very next access uses the new bank, including when 0 is written and bank 1 must appear.

// File: rtl/boot_mem_decoder.sv
module boot_mem_decoder #(
  parameter int BANK_W = 3,
  parameter int DATA_W = 8,
  localparam int WRAM_AW = BANK_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_mode,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] boot_rdata,
  input  logic [DATA_W-1:0] cart_rdata,
  input  logic [DATA_W-1:0] video_rdata,
  input  logic [DATA_W-1:0] wram_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              sel_boot,
  output logic              sel_cart_rom,
  output logic              sel_cart_ram,
  output logic              sel_video,
  output logic              sel_wram,
  output logic              sel_io,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic              boot_active,
  output logic [DATA_W-1:0] ie_mask,
  output logic [DATA_W-1:0] rdata
);

  logic              boot_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] ie_q;

  logic [7:0] off;
  logic page_ff, io_lo, hram, ie_hit, oam, boot_win, hit_boot_reg, hit_bank_reg;
  logic [BANK_W-1:0] bank_eff;

  assign off      = bus_addr[7:0];
  assign page_ff  = bus_addr[15:8] == 8'hFF;
  assign io_lo    = page_ff & ~bus_addr[7];
  assign ie_hit   = bus_addr == 16'hFFFF;
  assign hram     = page_ff & bus_addr[7] & ~ie_hit;
  assign oam      = bus_addr[15:8] == 8'hFE;
  assign boot_win = boot_q & ~bus_wr &
                    ((bus_addr <= 16'h00FE) |
                     (color_mode & bus_addr >= 16'h0200 & bus_addr <= 16'h08FF));

  assign hit_boot_reg = io_lo & (off == 8'h50);
  assign hit_bank_reg = io_lo & (off == 8'h70);

  assign sel_boot     = ~bus_addr[15] & boot_win;
  assign sel_cart_rom = ~bus_addr[15] & ~boot_win;
  assign sel_cart_ram = bus_addr[15:13] == 3'b101;
  assign sel_video    = (bus_addr[15:13] == 3'b100) | oam | hram;
  assign sel_wram     = (bus_addr[15:14] == 2'b11) & (bus_addr < 16'hFE00);

  always_comb begin
    sel_io = io_lo & ((off <= 8'h02) |
                      (off >= 8'h04 & off <= 8'h07) |
                      (off == 8'h0F) |
                      (off >= 8'h10 & off <= 8'h4F) |
                      (off >= 8'h51 & off <= 8'h55) |
                      (off >= 8'h60 & off <= 8'h6F) |
                      (off >= 8'h71));
  end

  assign bank_eff = color_mode ? bank_q : BANK_W'(1);

  always_comb begin
    case (bus_addr[15:12])
      4'hC:    wram_addr = {{BANK_W{1'b0}}, bus_addr[11:0]};
      4'hD:    wram_addr = {bank_eff, bus_addr[11:0]};
      default: wram_addr = WRAM_AW'(bus_addr[12:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      bank_q <= BANK_W'(1);
      ie_q   <= '0;
    end else begin
      if ((bus_rd & boot_q & bus_addr == 16'h00FE) | (bus_wr & hit_boot_reg))
        boot_q <= 1'b0;
      if (bus_wr & hit_bank_reg)
        bank_q <= (bus_wdata[BANK_W-1:0] == '0) ? BANK_W'(1) : bus_wdata[BANK_W-1:0];
      if (bus_wr & ie_hit)
        ie_q <= bus_wdata;
    end
  end

  always_comb begin
    if (sel_boot)                         rdata = boot_rdata;
    else if (sel_cart_rom | sel_cart_ram) rdata = cart_rdata;
    else if (sel_video)                   rdata = video_rdata;
    else if (sel_wram)                    rdata = wram_rdata;
    else if (sel_io)                      rdata = io_rdata;
    else if (hit_boot_reg)                rdata = {{(DATA_W-1){1'b0}}, boot_q};
    else if (hit_bank_reg)                rdata = DATA_W'(bank_q);
    else if (ie_hit)                      rdata = ie_q;
    else                                  rdata = '0;
  end

  assign boot_active = boot_q;
  assign ie_mask     = ie_q;

endmodule

// File: rtl/boot_mem_decoder_chk.sv
module boot_mem_decoder_chk #(
  parameter int BANK_W = 3,
  parameter int DATA_W = 8,
  localparam int WRAM_AW = BANK_W + 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] boot_rdata,
  input logic              sel_boot,
  input logic              sel_cart_rom,
  input logic              sel_cart_ram,
  input logic              sel_video,
  input logic              sel_wram,
  input logic              sel_io,
  input logic [WRAM_AW-1:0] wram_addr,
  input logic              boot_active,
  input logic [DATA_W-1:0] ie_mask,
  input logic [DATA_W-1:0] rdata
);

  a_r1_boot_data: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot && bus_rd |-> rdata == boot_rdata);

  a_r2_fe_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    boot_active && bus_rd && bus_addr == 16'h00FE |=> !boot_active);

  a_r4_ctrl_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 16'hFF50 |=> !boot_active);

  a_r4_boot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active);

  a_r5_banked_not_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wram && bus_addr[15:12] == 4'hD |-> wram_addr[WRAM_AW-1 -: BANK_W] != '0);

  a_r7_echo_low_banks: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wram && bus_addr[15:13] == 3'b111 |-> wram_addr[WRAM_AW-1:13] == '0);

  a_r9_ie_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 16'hFFFF |=> ie_mask == $past(bus_wdata));

  a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_boot, sel_cart_rom, sel_cart_ram, sel_video, sel_wram, sel_io}));

endmodule

bind boot_mem_decoder boot_mem_decoder_chk #(.BANK_W(BANK_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/boot_mem_decoder_tb_top.sv
module boot_mem_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic color_mode = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] boot_rdata = 8'hB0, cart_rdata = 8'hCA, video_rdata = 8'h71,
              wram_rdata = 8'h3E, io_rdata = 8'h10;
  logic sel_boot, sel_cart_rom, sel_cart_ram, sel_video, sel_wram, sel_io;
  logic [14:0] wram_addr;
  logic boot_active;
  logic [7:0] ie_mask, rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] c_data;
  logic [5:0] c_sel;
  logic [14:0] c_wa;

  localparam logic [5:0] S_BOOT = 6'b100000, S_CROM = 6'b010000, S_CRAM = 6'b001000,
                         S_VID = 6'b000100, S_WRAM = 6'b000010, S_IO = 6'b000001;

  always #2 clk = ~clk;

  boot_mem_decoder dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic col);
    @(negedge clk);
    rst_n = 1'b0; color_mode = col; bus_rd = 0; bus_wr = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    c_data = rdata;
    c_sel = {sel_boot, sel_cart_rom, sel_cart_ram, sel_video, sel_wram, sel_io};
    c_wa = wram_addr;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    c_sel = {sel_boot, sel_cart_rom, sel_cart_ram, sel_video, sel_wram, sel_io};
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    #1;
    chk("R4 reset boot_active", boot_active, 1);
    chk("R9 reset ie_mask", ie_mask, 8'h00);
    rd(16'hFF70); chk("R6 reset bank", c_data, 8'h01);
    rd(16'hFF50); chk("R4 flag read active", c_data, 8'h01);
  endtask

  task automatic t_overlay;
    do_reset(1'b1);
    rd(16'h0000); chk("R1 0000 sel", c_sel, S_BOOT); chk("R1 0000 data", c_data, 8'hB0);
    rd(16'h00FD); chk("R1 00FD data", c_data, 8'hB0);
    rd(16'h00FF); chk("R1 00FF sel", c_sel, S_CROM); chk("R1 00FF data", c_data, 8'hCA);
    rd(16'h0150); chk("R1 0150 data", c_data, 8'hCA);
    wr(16'h0010, 8'h05); chk("R1 rom write to cart", c_sel, S_CROM);
  endtask

  task automatic t_color_window;
    do_reset(1'b1);
    rd(16'h0200); chk("R3 0200 colour", c_sel, S_BOOT);
    rd(16'h08FF); chk("R3 08FF colour", c_data, 8'hB0);
    rd(16'h0900); chk("R3 0900 colour", c_sel, S_CROM);
    rd(16'h01FF); chk("R3 01FF colour", c_sel, S_CROM);
    do_reset(1'b0);
    rd(16'h0200); chk("R3 0200 mono", c_sel, S_CROM);
    rd(16'h0000); chk("R3 0000 mono", c_sel, S_BOOT);
  endtask

  task automatic t_fe_clear;
    do_reset(1'b1);
    rd(16'h00FE);
    chk("R2 FE read data", c_data, 8'hB0);
    chk("R2 FE read sel", c_sel, S_BOOT);
    chk("R2 flag dropped", boot_active, 0);
    rd(16'h0000); chk("R2 0000 after", c_data, 8'hCA);
    rd(16'h0200); chk("R2 0200 after", c_sel, S_CROM);
    rd(16'hFF50); chk("R4 flag read cleared", c_data, 8'h00);
  endtask

  task automatic t_ctrl_clear;
    do_reset(1'b1);
    wr(16'hFF50, 8'h00);
    chk("R4 write clears", boot_active, 0);
    wr(16'hFF50, 8'h01);
    chk("R4 stays clear", boot_active, 0);
    rd(16'h0010); chk("R4 cart after clear", c_sel, S_CROM);
  endtask

  task automatic t_bank;
    do_reset(1'b1);
    rd(16'hD123); chk("R5 reset banked", c_wa, 15'h1123); chk("R5 sel", c_sel, S_WRAM);
    wr(16'hFF70, 8'h05);
    rd(16'hD123); chk("R5 bank5 addr", c_wa, 15'h5123); chk("R5 data", c_data, 8'h3E);
    rd(16'hFF70); chk("R6 read 5", c_data, 8'h05);
    rd(16'hC456); chk("R5 fixed window", c_wa, 15'h0456);
    wr(16'hFF70, 8'h00);
    rd(16'hD000); chk("R6 zero as one addr", c_wa, 15'h1000);
    rd(16'hFF70); chk("R6 zero as one", c_data, 8'h01);
    wr(16'hFF70, 8'hFF);
    rd(16'hDFFF); chk("R5 bank7 addr", c_wa, 15'h7FFF);
    rd(16'hFF70); chk("R6 mask 7", c_data, 8'h07);
    wr(16'hFF70, 8'h08);
    rd(16'hFF70); chk("R6 08 -> 1", c_data, 8'h01);
    wr(16'hFF70, 8'h0A);
    rd(16'hFF70); chk("R6 0A -> 2", c_data, 8'h02);
    do_reset(1'b0);
    wr(16'hFF70, 8'h03);
    rd(16'hD010); chk("R5 mono bank1", c_wa, 15'h1010);
  endtask

  task automatic t_echo;
    do_reset(1'b1);
    wr(16'hFF70, 8'h06);
    rd(16'hE123); chk("R7 E123", c_wa, 15'h0123); chk("R7 sel", c_sel, S_WRAM);
    rd(16'hF456); chk("R7 F456", c_wa, 15'h1456);
    rd(16'hFDFF); chk("R7 FDFF", c_wa, 15'h1DFF); chk("R7 data", c_data, 8'h3E);
  endtask

  task automatic t_regions;
    logic [15:0] vaddr [6] = '{16'h8000, 16'h9FFF, 16'hFE00, 16'hFEFF, 16'hFF80, 16'hFFFE};
    do_reset(1'b1);
    foreach (vaddr[i]) begin
      rd(vaddr[i]); chk("R8 video sel", c_sel, S_VID); chk("R8 video data", c_data, 8'h71);
    end
    rd(16'hA000); chk("R8 A000", c_sel, S_CRAM);
    rd(16'hBFFF); chk("R8 BFFF", c_sel, S_CRAM); chk("R8 cart ram data", c_data, 8'hCA);
    rd(16'h4000); chk("R8 4000 cart rom", c_sel, S_CROM);
    for (int a = 0; a < 65536; a += 257) begin
      rd(16'(a)); chk("R11 one select", 32'($countones(c_sel)) <= 1, 1);
    end
  endtask

  task automatic t_ie;
    do_reset(1'b1);
    wr(16'hFFFF, 8'h1F);
    chk("R9 ie_mask", ie_mask, 8'h1F); chk("R9 no select", c_sel, 6'b0);
    rd(16'hFFFF); chk("R9 readback", c_data, 8'h1F);
    wr(16'hFFFF, 8'hA0);
    rd(16'hFFFF); chk("R9 reload", c_data, 8'hA0);
  endtask

  task automatic t_io;
    do_reset(1'b1);
    wr(16'hFFFF, 8'h15);
    wr(16'hFF70, 8'h04);
    rd(16'hFF03); chk("R10 FF03 data", c_data, 8'h00); chk("R10 FF03 sel", c_sel, 6'b0);
    rd(16'hFF08); chk("R10 FF08 data", c_data, 8'h00);
    rd(16'hFF56); chk("R10 FF56 data", c_data, 8'h00);
    rd(16'hFF04); chk("R10 FF04 sel", c_sel, S_IO); chk("R10 FF04 data", c_data, 8'h10);
    rd(16'hFF47); chk("R10 FF47 sel", c_sel, S_IO);
    rd(16'hFF0F); chk("R10 FF0F sel", c_sel, S_IO);
    rd(16'hFF53); chk("R10 FF53 sel", c_sel, S_IO);
    wr(16'hFF03, 8'hAA); chk("R10 write unmapped sel", c_sel, 6'b0);
    wr(16'hFF5A, 8'h00);
    rd(16'hFF70); chk("R10 bank kept", c_data, 8'h04);
    rd(16'hFFFF); chk("R10 ie kept", c_data, 8'h15);
    chk("R10 boot kept", boot_active, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state;
    t_overlay;
    t_color_window;
    t_fe_clear;
    t_ctrl_clear;
    t_bank;
    t_echo;
    t_regions;
    t_ie;
    t_io;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule